// File: doc/BRIEF.md
# Program Counter with Return-Address Stack

This block keeps the instruction address of a small sequencer and a hardware stack of return addresses. In a normal cycle the address advances by one and wraps from the top of the 11-bit space back to zero. A subroutine call stores the address of the next instruction on the stack and jumps to a target built from two sources. The low ten bits come from the immediate field of the call. The top bit is bit 2 of a separate page-high buffer register. A return pops the newest stored address back into the counter.

Both call and return take two cycles. In the first cycle the counter and the stack are updated. The second cycle is a flush: the instruction prefetched behind the jump is thrown away, the counter holds, and `busy_o` is high. A stall input freezes the whole block. The stack is circular. When it is full, a new push overwrites the oldest entry and sets a sticky overflow flag.

Top module: `progctr_stack`

## Requirements
- R1: While reset is asserted, and after it is released until the first unstalled cycle, `pc_o` is 0, `depth_o` is 0, `empty_o` is 1, and `full_o`, `ovf_o` and `busy_o` are 0.
- R2: In an unstalled cycle with `busy_o` low and neither `call_i` nor `ret_i` asserted, `pc_o` advances by one at the clock edge, and 2047 is followed by 0.
- R3: A call that is accepted (unstalled, `busy_o` low, `call_i` high) loads `pc_o` with `page_i[2]` as bit 10 and `imm_i` as bits 9..0. The other bits of `page_i` have no effect.
- R4: An accepted call pushes the old `pc_o` plus one, taken modulo 2048, as the return address. When the stack is not full, `depth_o` rises by one.
- R5: After an accepted call or return, `busy_o` is high for exactly one unstalled cycle. During that cycle `pc_o` holds, and any `call_i` or `ret_i` is ignored.
- R6: An accepted return (unstalled, `busy_o` low, `call_i` low, `ret_i` high) loads `pc_o` with the newest stored address and lowers `depth_o` by one.
- R7: When `call_i` and `ret_i` are both high in an accepting cycle, the call is performed and the return is dropped.
- R8: While `stall_i` is high, `pc_o`, `busy_o`, the stack contents and all flags hold, and any `call_i` or `ret_i` is ignored.
- R9: The stack holds 8 entries. A push while `depth_o` is 8 overwrites the oldest entry, leaves `depth_o` at 8 and sets `ovf_o`, which stays set until reset. `full_o` is high exactly when `depth_o` is 8.
- R10: A return while the stack is empty leaves `depth_o` at 0 and `empty_o` at 1. It still moves the circular pointer back one slot and loads `pc_o` from that slot.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| stall_i | input | 1 | Freezes the whole block for the cycle |
| call_i | input | 1 | Call strobe |
| ret_i | input | 1 | Return (pop) strobe |
| imm_i | input | 10 | Call target bits 9..0 |
| page_i | input | 8 | Page-high buffer register; bit 2 becomes target bit 10 |
| pc_o | output | 11 | Current program counter |
| busy_o | output | 1 | Flush cycle of a call or return |
| depth_o | output | 4 | Number of valid stack entries, 0 to 8 |
| full_o | output | 1 | Stack holds 8 entries |
| empty_o | output | 1 | Stack holds no entries |
| ovf_o | output | 1 | Sticky flag: a push overwrote an entry |

## Verification
The bench builds the block with its default parameters: an 8-entry stack and an 11-bit counter with a 10-bit immediate. With eight entries, nine nested calls are enough to overwrite the oldest entry, and the later pops walk the whole ring, including a pop from an empty stack that revisits a slot. With an 11-bit counter, a single call to address 2047 puts both the wrap to zero and the wrapped return address one step away, so no long run of increments is needed.

// File: rtl/progctr_pkg.sv
package progctr_pkg;
  typedef enum logic [1:0] {
    PC_STEP = 2'd0,
    PC_CALL = 2'd1,
    PC_RET  = 2'd2,
    PC_HOLD = 2'd3
  } pc_op_e;
endpackage

// File: rtl/progctr_rstsync.sv
module progctr_rstsync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_o = sync_q[1];
endmodule

// File: rtl/progctr_seq.sv
module progctr_seq
  import progctr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   stall_i,
  input  logic   call_i,
  input  logic   ret_i,
  output pc_op_e op_o,
  output logic   busy_o
);
  logic busy_q, busy_d;
  pc_op_e op;

  // Decode: stall and flush both hold; call has priority over return.
  always_comb begin
    if (stall_i || busy_q) op = PC_HOLD;
    else if (call_i)       op = PC_CALL;
    else if (ret_i)        op = PC_RET;
    else                   op = PC_STEP;
  end

  always_comb begin
    busy_d = busy_q;
    if (!stall_i) busy_d = (op == PC_CALL) || (op == PC_RET);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy_d;
  end

  assign op_o   = op;
  assign busy_o = busy_q;
endmodule

// File: rtl/progctr_ras.sv
module progctr_ras #(
  parameter  int DEPTH = 8,
  parameter  int W     = 11,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     wdata_i,
  output logic [W-1:0]     top_o,
  output logic [CNT_W-1:0] depth_o,
  output logic             full_o,
  output logic             empty_o,
  output logic             ovf_o
);
  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(DEPTH);

  logic [PTR_W-1:0] wp_q, wp_d, wp_inc, wp_dec;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             ovf_q, ovf_d;
  logic [W-1:0]     slots [DEPTH];

  assign wp_inc = (wp_q == PTR_LAST) ? '0 : wp_q + 1'b1;
  assign wp_dec = (wp_q == '0) ? PTR_LAST : wp_q - 1'b1;

  assign full_o  = (cnt_q == CNT_MAX);
  assign empty_o = (cnt_q == '0);

  // Slot storage: one register per entry, written when the pointer selects it.
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic [W-1:0] slot_q;
    logic         we;
    assign we = push_i && (wp_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (we) slot_q <= wdata_i;
    end
    assign slots[g] = slot_q;
  end

  always_comb begin
    wp_d  = wp_q;
    cnt_d = cnt_q;
    ovf_d = ovf_q;
    if (push_i) begin
      wp_d = wp_inc;
      if (full_o) ovf_d = 1'b1;
      else        cnt_d = cnt_q + 1'b1;
    end else if (pop_i) begin
      wp_d = wp_dec;
      if (!empty_o) cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      wp_q  <= wp_d;
      cnt_q <= cnt_d;
      ovf_q <= ovf_d;
    end
  end

  assign top_o   = slots[wp_dec];
  assign depth_o = cnt_q;
  assign ovf_o   = ovf_q;
endmodule

// File: rtl/progctr_pcreg.sv
module progctr_pcreg
  import progctr_pkg::*;
#(
  parameter int PC_W     = 11,
  parameter int IMM_W    = 10,
  parameter int PAGE_W   = 8,
  parameter int PAGE_BIT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  pc_op_e            op_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PAGE_W-1:0] page_i,
  input  logic [PC_W-1:0]   tos_i,
  output logic [PC_W-1:0]   pc_o,
  output logic [PC_W-1:0]   ret_addr_o
);
  logic [PC_W-1:0] pc_q, pc_d, pc_inc, target;

  assign pc_inc = pc_q + 1'b1;
  assign target = PC_W'({page_i[PAGE_BIT], imm_i});

  always_comb begin
    unique case (op_i)
      PC_STEP: pc_d = pc_inc;
      PC_CALL: pc_d = target;
      PC_RET:  pc_d = tos_i;
      default: pc_d = pc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pc_q <= '0;
    else        pc_q <= pc_d;
  end

  assign pc_o       = pc_q;
  assign ret_addr_o = pc_inc;
endmodule

// File: rtl/progctr_stack.sv
module progctr_stack
  import progctr_pkg::*;
#(
  parameter  int PC_W     = 11,
  parameter  int IMM_W    = 10,
  parameter  int PAGE_W   = 8,
  parameter  int PAGE_BIT = 2,
  parameter  int DEPTH    = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stall_i,
  input  logic              call_i,
  input  logic              ret_i,
  input  logic [IMM_W-1:0]  imm_i,
  input  logic [PAGE_W-1:0] page_i,
  output logic [PC_W-1:0]   pc_o,
  output logic              busy_o,
  output logic [CNT_W-1:0]  depth_o,
  output logic              full_o,
  output logic              empty_o,
  output logic              ovf_o
);
  logic            rst_n_s;
  pc_op_e          op;
  logic [PC_W-1:0] tos, ret_addr;

  progctr_rstsync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_s)
  );

  progctr_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .stall_i (stall_i),
    .call_i  (call_i),
    .ret_i   (ret_i),
    .op_o    (op),
    .busy_o  (busy_o)
  );

  progctr_ras #(.DEPTH(DEPTH), .W(PC_W)) u_ras (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .push_i  (op == PC_CALL),
    .pop_i   (op == PC_RET),
    .wdata_i (ret_addr),
    .top_o   (tos),
    .depth_o (depth_o),
    .full_o  (full_o),
    .empty_o (empty_o),
    .ovf_o   (ovf_o)
  );

  progctr_pcreg #(.PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_BIT(PAGE_BIT)) u_pc (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .op_i       (op),
    .imm_i      (imm_i),
    .page_i     (page_i),
    .tos_i      (tos),
    .pc_o       (pc_o),
    .ret_addr_o (ret_addr)
  );
endmodule

// File: rtl/progctr_stack_chk.sv
module progctr_stack_chk #(
  parameter  int PC_W     = 11,
  parameter  int IMM_W    = 10,
  parameter  int PAGE_W   = 8,
  parameter  int PAGE_BIT = 2,
  parameter  int DEPTH    = 8,
  localparam int CNT_W    = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              stall_i,
  input logic              call_i,
  input logic              ret_i,
  input logic [IMM_W-1:0]  imm_i,
  input logic [PAGE_W-1:0] page_i,
  input logic [PC_W-1:0]   pc_o,
  input logic              busy_o,
  input logic [CNT_W-1:0]  depth_o,
  input logic              full_o,
  input logic              empty_o,
  input logic              ovf_o
);
  logic idle_step, take_call;
  assign idle_step = !stall_i && !busy_o && !call_i && !ret_i;
  assign take_call = !stall_i && !busy_o && call_i;

  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    idle_step |=> pc_o == PC_W'($past(pc_o) + 1'b1));

  a_r3_call_target: assert property (@(posedge clk) disable iff (!rst_n)
    take_call |=> pc_o == PC_W'({$past(page_i[PAGE_BIT]), $past(imm_i)}));

  a_r4_call_depth: assert property (@(posedge clk) disable iff (!rst_n)
    (take_call && !full_o) |=> depth_o == CNT_W'($past(depth_o) + 1'b1));

  a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !stall_i) |=> !busy_o);

  a_r5_flush_hold: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> $stable(pc_o) && $stable(depth_o));

  a_r8_stall_freeze: assert property (@(posedge clk) disable iff (!rst_n)
    stall_i |=> $stable(pc_o) && $stable(depth_o) && $stable(busy_o) && $stable(ovf_o));

  a_r9_depth_bound: assert property (@(posedge clk) disable iff (!rst_n)
    depth_o <= CNT_W'(DEPTH));

  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |=> ovf_o);

  a_r10_empty_floor: assert property (@(posedge clk) disable iff (!rst_n)
    (empty_o && !stall_i && !busy_o && !call_i && ret_i) |=> empty_o);
endmodule

bind progctr_stack progctr_stack_chk #(
  .PC_W(PC_W), .IMM_W(IMM_W), .PAGE_W(PAGE_W), .PAGE_BIT(PAGE_BIT), .DEPTH(DEPTH)
) u_chk (.*);

// File: tb/progctr_stack_bench.sv
`timescale 1ns/1ps
module progctr_stack_bench;
  localparam int D = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        stall_i, call_i, ret_i;
  logic [9:0]  imm_i;
  logic [7:0]  page_i;
  logic [10:0] pc_o;
  logic        busy_o, full_o, empty_o, ovf_o;
  logic [3:0]  depth_o;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Reference state, kept from the requirements.
  int m_pc, m_cnt, m_wp;
  bit m_busy, m_ovf;
  int m_mem [D];

  always #10 clk = ~clk;

  progctr_stack u_progctr_stack (
    .clk(clk), .rst_n(rst_n), .stall_i(stall_i), .call_i(call_i), .ret_i(ret_i),
    .imm_i(imm_i), .page_i(page_i), .pc_o(pc_o), .busy_o(busy_o), .depth_o(depth_o),
    .full_o(full_o), .empty_o(empty_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk(tag, "pc", int'(pc_o), m_pc);
    chk(tag, "busy", int'(busy_o), int'(m_busy));
    chk(tag, "depth", int'(depth_o), m_cnt);
    chk(tag, "full", int'(full_o), int'(m_cnt == D));
    chk(tag, "empty", int'(empty_o), int'(m_cnt == 0));
    chk(tag, "ovf", int'(ovf_o), int'(m_ovf));
  endtask

  // One clock cycle: drive, predict, then sample after the edge.
  task automatic cyc(input string tag, input bit c, input bit r, input bit s,
                     input int im, input int pg);
    @(negedge clk);
    call_i = c; ret_i = r; stall_i = s;
    imm_i = 10'(im); page_i = 8'(pg);
    if (!s) begin
      if (m_busy) m_busy = 0;
      else if (c) begin
        m_mem[m_wp] = (m_pc + 1) % 2048;
        m_wp = (m_wp + 1) % D;
        if (m_cnt == D) m_ovf = 1; else m_cnt++;
        m_pc = ((pg >> 2) & 1) * 1024 + (im & 1023);
        m_busy = 1;
      end else if (r) begin
        m_wp = (m_wp + D - 1) % D;
        m_pc = m_mem[m_wp];
        if (m_cnt > 0) m_cnt--;
        m_busy = 1;
      end else m_pc = (m_pc + 1) % 2048;
    end
    @(posedge clk); #1;
    check_all(tag);
  endtask

  task automatic t_reset();
    rst_n = 0; stall_i = 1; call_i = 0; ret_i = 0; imm_i = '0; page_i = '0;
    m_pc = 0; m_cnt = 0; m_wp = 0; m_busy = 0; m_ovf = 0;
    repeat (3) @(posedge clk);
    #1 check_all("R1");
    @(negedge clk); rst_n = 1;
    repeat (4) cyc("R1", 0, 0, 1, 0, 0);
  endtask

  task automatic t_step();
    repeat (5) cyc("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_call();
    cyc("R3", 1, 0, 0, 'h155, 'hFB);   // page bit 2 clear, others set
    cyc("R5", 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 'h2AA, 'h04);
    cyc("R5", 1, 1, 0, 'h0F0, 'hFF);   // strobes during flush ignored
    cyc("R2", 0, 0, 0, 0, 0);
  endtask

  task automatic t_ret();
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R5", 0, 1, 0, 0, 0);
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_both();
    cyc("R7", 1, 1, 0, 'h033, 'h04);
    cyc("R7", 0, 0, 0, 0, 0);
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_stall();
    repeat (3) cyc("R8", 1, 1, 1, 'h111, 'h04);
    cyc("R3", 1, 0, 0, 'h222, 'h00);
    repeat (2) cyc("R8", 0, 0, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0);
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R8", 0, 0, 1, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0);
  endtask

  task automatic t_overflow();
    for (int i = 0; i < D + 1; i++) begin
      cyc("R9", 1, 0, 0, 'h040 + i * 7, (i % 2) * 4);
      cyc("R9", 0, 0, 0, 0, 0);
    end
    for (int i = 0; i < D; i++) begin
      cyc("R9", 0, 1, 0, 0, 0);
      cyc("R9", 0, 0, 0, 0, 0);
    end
  endtask

  task automatic t_underflow();
    cyc("R10", 0, 1, 0, 0, 0);
    cyc("R10", 0, 0, 0, 0, 0);
  endtask

  task automatic t_wrap();
    cyc("R3", 1, 0, 0, 'h3FF, 'h04);
    cyc("R5", 0, 0, 0, 0, 0);
    cyc("R2", 0, 0, 0, 0, 0);           // 2047 -> 0
    cyc("R3", 1, 0, 0, 'h3FF, 'h04);
    cyc("R5", 0, 0, 0, 0, 0);
    cyc("R4", 1, 0, 0, 'h005, 'h00);    // pushes 0
    cyc("R5", 0, 0, 0, 0, 0);
    cyc("R6", 0, 1, 0, 0, 0);
    cyc("R5", 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_step();
    t_call();
    t_ret();
    t_both();
    t_stall();
    t_overflow();
    t_underflow();
    t_wrap();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule